// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles, producing one quotient bit per cycle, most significant bit first. It never restores the partial remainder. The sign of the running remainder alone decides the next step. While that remainder is non-negative, the block shifts it left, brings in the next dividend bit and subtracts the divisor. While it is negative, the block adds the divisor instead. The new sign gives the quotient bit: 1 when non-negative, 0 when negative. Because a negative digit is stored as 0, the collected bits are already the plain binary quotient.

All additions and subtractions go through one shared carry-lookahead adder/subtractor. After the last quotient bit, a single correction cycle adds the divisor back if the remainder is still negative. The remainder is kept one bit wider than the operands, so its sign can be observed. The quotient is not touched by the correction.

A caller pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` pulse and reads the quotient and remainder, which stay valid until the next completion. A zero divisor does not run the loop. It reports a flag and returns fixed values on the next cycle.

Top module: `nrdiv_unit`

## Requirements
- R1: For a non-zero divisor, `quot_o` equals floor(dividend/divisor) and `rem_o` equals dividend mod divisor. For example, 29 divided by 11 gives 2 remainder 7.
- R2: `rem_o` is W+1 bits wide. Its top bit, the sign, is 0 whenever `done_o` reports a non-zero-divisor result.
- R3: With a non-zero divisor, `done_o` goes high W+1 clock cycles after the edge that accepts `start_i`. `busy_o` is high from the cycle after acceptance up to, but not including, the `done_o` cycle.
- R4: `done_o` is high for exactly one cycle. `quot_o` and `rem_o` hold their values until the next completion.
- R5: A zero divisor makes `done_o` and `dz_o` high in the cycle after acceptance, with `quot_o` all ones and `rem_o` = {0, dividend}. `busy_o` stays low throughout.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its operands and its latency.
- R7: A `start_i` pulse in the cycle where `done_o` is high is accepted as a new operation. A non-zero-divisor operation clears `dz_o`.
- R8: After reset, `busy_o`, `done_o` and `dz_o` are 0 and `quot_o` and `rem_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a division |
| dividend_i | input | W | Unsigned dividend, sampled when the request is accepted |
| divisor_i | input | W | Unsigned divisor, sampled when the request is accepted |
| busy_o | output | 1 | An iteration or correction cycle is in progress |
| done_o | output | 1 | One-cycle pulse: results are valid |
| dz_o | output | 1 | The last result came from a zero divisor |
| quot_o | output | W | Quotient |
| rem_o | output | W+1 | Remainder, with its sign bit as the top bit |

## Verification
Two events can share a cycle. A new request can arrive in the cycle that carries the `done_o` pulse of the previous result, and a request can arrive during the correction cycle, which is still busy. The bench provokes both. It issues operations back to back with no idle gap, so each new `start_i` coincides with the prior `done_o`. It also injects stray requests at every busy cycle, including the last one. It judges the outcome from the results and the measured latency: an accepted back-to-back request must produce its own quotient on time, and a stray request must leave both the result and the W+1 cycle latency of the running operation unchanged.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_t;
endpackage

// File: rtl/nrdiv_cla.sv
// Carry-lookahead adder/subtractor: every carry is a sum of products of the
// bit generate/propagate terms and the carry-in, with no carry chain.
module nrdiv_cla #(
  parameter int N = 10
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o
);
  logic [N-1:0] bx;
  logic [N-1:0] prop;
  logic [N-2:0] gen;
  logic [N-1:0] carry;

  assign bx   = b_i ^ {N{sub_i}};
  assign prop = a_i ^ bx;
  assign gen  = a_i[N-2:0] & bx[N-2:0];

  always_comb begin
    carry    = '0;
    carry[0] = sub_i;
    for (int i = 1; i < N; i++) begin
      logic run;
      logic c;
      run = 1'b1;
      c   = 1'b0;
      for (int m = i - 1; m >= 0; m--) begin
        c   = c | (gen[m] & run);
        run = run & prop[m];
      end
      carry[i] = c | (sub_i & run);
    end
  end

  assign sum_o = prop ^ carry;
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int ITERS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_dsr_i,
  output logic busy_o,
  output logic load_o,
  output logic zload_o,
  output logic step_o,
  output logic fix_o
);
  localparam int CW = $clog2(ITERS + 1);

  nrdiv_state_t  st_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept  = start_i && (st_q == ST_IDLE);
  assign load_o  = accept && !zero_dsr_i;
  assign zload_o = accept && zero_dsr_i;
  assign step_o  = (st_q == ST_RUN);
  assign fix_o   = (st_q == ST_FIX);
  assign busy_o  = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (load_o) st_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(ITERS - 1)) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] quot_o,
  output logic [W:0]   rem_o
);
  localparam int RW = W + 1;

  logic          load, zload, step, fix;
  logic [RW-1:0] acc_q;
  logic [W-1:0]  qsh_q;
  logic [W-1:0]  dsr_q;
  logic [RW-1:0] add_a, add_b, add_s;
  logic          add_sub;

  nrdiv_ctrl #(.ITERS(W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .zero_dsr_i (divisor_i == '0),
    .busy_o     (busy_o),
    .load_o     (load),
    .zload_o    (zload),
    .step_o     (step),
    .fix_o      (fix)
  );

  // One adder serves both the iterations and the final correction.
  always_comb begin
    add_b = {1'b0, dsr_q};
    if (fix) begin
      add_a   = acc_q;
      add_sub = 1'b0;
    end else begin
      add_a   = {acc_q[RW-2:0], qsh_q[W-1]};
      add_sub = ~acc_q[RW-1];
    end
  end

  nrdiv_cla #(.N(RW)) u_cla (
    .a_i   (add_a),
    .b_i   (add_b),
    .sub_i (add_sub),
    .sum_o (add_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      qsh_q  <= '0;
      dsr_q  <= '0;
      done_o <= 1'b0;
      dz_o   <= 1'b0;
      quot_o <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= zload | fix;
      if (load) begin
        acc_q <= '0;
        qsh_q <= dividend_i;
        dsr_q <= divisor_i;
        dz_o  <= 1'b0;
      end
      if (zload) begin
        dz_o   <= 1'b1;
        quot_o <= '1;
        rem_o  <= {1'b0, dividend_i};
      end
      if (step) begin
        acc_q <= add_s;
        qsh_q <= {qsh_q[W-2:0], ~add_s[RW-1]};
      end
      if (fix) begin
        quot_o <= qsh_q;
        rem_o  <= acc_q[RW-1] ? add_s : acc_q;
      end
    end
  end
endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         dz_o,
  input logic [W-1:0] quot_o,
  input logic [W:0]   rem_o
);
  localparam int LAT = W + 2;  // edges counted from the accepting edge, inclusive
  localparam int LCW = $clog2(LAT + 2) + 1;
  localparam int PW  = 2 * W + 1;

  logic [W-1:0]   n_q, d_q;
  logic [LCW-1:0] lat_q;
  logic [PW-1:0]  recon;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= '0;
      d_q   <= '0;
      lat_q <= '0;
    end else if (start_i && !busy_o) begin
      n_q   <= dividend_i;
      d_q   <= divisor_i;
      lat_q <= LCW'(1);
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assign recon = PW'(quot_o) * PW'(d_q) + PW'(rem_o);

  p_identity_r1: assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o) |-> (recon == PW'(n_q)) && (rem_o < {1'b0, d_q}));

  p_rem_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o) |-> !rem_o[W]);

  // Also covers R6: a stray request during busy would otherwise restart the count.
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o) |-> (lat_q == LCW'(LAT)));

  p_busy_done_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !(start_i && divisor_i == '0)) |=> !done_o);

  p_zero_div_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && divisor_i == '0) |=>
      (done_o && dz_o && !busy_o && (quot_o == '1) &&
       (rem_o == {1'b0, $past(dividend_i)})));
endmodule

bind nrdiv_unit nrdiv_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dz_o       (dz_o),
  .quot_o     (quot_o),
  .rem_o      (rem_o)
);

// File: tb/nrdiv_unit_tb.sv
`timescale 1ns/1ps
module nrdiv_unit_tb;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o, dz_o;
  logic [W-1:0] quot_o;
  logic [W:0]   rem_o;

  int nchk  = 0;
  int nfail = 0;
  bit have_prev = 0;
  logic [W-1:0] prev_q;

  always #2.5 clk = ~clk;

  nrdiv_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  function automatic int exp_quot(input int n, input int d);
    return (d == 0) ? (1 << W) - 1 : n / d;
  endfunction

  function automatic int exp_rem(input int n, input int d);
    return (d == 0) ? n : n % d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  // Starts at a negedge, returns at the negedge on which done_o is seen.
  task automatic do_div(input int n, input int d, input int inj,
                        input int jn, input int jd);
    int cyc = 0;
    bit seen = 0;
    string rq;
    start_i    = 1'b1;
    dividend_i = W'(n);
    divisor_i  = W'(d);
    while (!seen && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cyc == inj) begin
        start_i = 1'b1; dividend_i = W'(jn); divisor_i = W'(jd);  // R6 stray request
      end else begin
        start_i = 1'b0;
      end
      if (cyc == 1) begin
        if (d == 0) chk(busy_o == 1'b0, "R5", "busy on zero divisor", int'(busy_o), 0);
        else begin
          chk(busy_o == 1'b1, "R3", "busy after accept", int'(busy_o), 1);
          if (have_prev) chk(done_o == 1'b0, "R4", "done pulse width", int'(done_o), 0);
        end
      end
      if (cyc == 5 && d != 0 && have_prev)
        chk(quot_o == prev_q, "R4", "quotient hold", int'(quot_o), int'(prev_q));
      if (done_o) seen = 1;
    end
    rq = (d == 0) ? "R5" : "R1";
    chk(seen, "R3", "done seen", int'(seen), 1);
    chk(cyc == ((d == 0) ? 1 : W + 2), (d == 0) ? "R5" : "R3/R6", "latency",
        cyc, (d == 0) ? 1 : W + 2);
    chk(int'(quot_o) == exp_quot(n, d), rq, "quotient", int'(quot_o), exp_quot(n, d));
    chk(int'(rem_o) == exp_rem(n, d), rq, "remainder", int'(rem_o), exp_rem(n, d));
    chk(dz_o == (d == 0), (d == 0) ? "R5" : "R7", "dz flag", int'(dz_o), int'(d == 0));
    if (d != 0) chk(rem_o[W] == 1'b0, "R2", "remainder sign", int'(rem_o[W]), 0);
    prev_q    = quot_o;
    have_prev = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, d, inj;
    void'($urandom(32'd4242));
    rst = 1'b1; start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(busy_o == 0, "R8", "busy", int'(busy_o), 0);
    chk(done_o == 0, "R8", "done", int'(done_o), 0);
    chk(dz_o == 0, "R8", "dz", int'(dz_o), 0);
    chk(quot_o == 0 && rem_o == 0, "R8", "results", int'(quot_o) + int'(rem_o), 0);

    do_div(29, 11, 0, 0, 0);     // R1 worked example
    do_div(0, 5, 0, 0, 0);
    do_div(511, 1, 0, 0, 0);
    do_div(511, 511, 0, 0, 0);
    do_div(5, 511, 0, 0, 0);
    do_div(256, 255, 0, 0, 0);
    do_div(100, 0, 0, 0, 0);     // R5
    do_div(511, 0, 0, 0, 0);     // R5 back to back with another zero divisor
    do_div(29, 11, 0, 0, 0);     // R7 clears dz after zero divisor
    do_div(400, 7, 2, 3, 0);     // R6 stray zero-divisor request early in the loop
    do_div(333, 10, 10, 1, 1);   // R6 stray request in the correction cycle
    do_div(1, 1, 6, 500, 3);
    for (int k = 0; k < 80; k++) begin
      n   = int'($urandom % 512);
      d   = ($urandom % 8 == 0) ? 0 : int'($urandom % 512);
      inj = ($urandom % 3 == 0 && d != 0) ? 2 + int'($urandom % 9) : 0;
      do_div(n, d, inj, int'($urandom % 512), int'($urandom % 512));
    end
    @(negedge clk);
    summary();
    $finish;
  end
endmodule